// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block supervises data and control hazards in an in-order, five-stage pipeline (fetch, decode, execute, memory, write-back). In every cycle it compares the two source register numbers of the instruction now in execute with the destination numbers held in the execute/memory and memory/write-back pipeline registers. From that comparison it produces one bypass select per ALU operand, so a dependent instruction uses the newest result and not the stale register-file value. Write-after-read and write-after-write dependences need no action in this pipeline, so the block does not look for them. Register reads in decode and writes in write-back use separate ports, so they never cause a stall.

A load in execute that writes a register read by the instruction in decode cannot be bypassed in time. The block then holds the program counter and the fetch/decode register for one clock and turns the decode/execute register into an all-zero no-op word. A taken branch is resolved in execute. When it is signalled, the block clears both the fetch/decode and the decode/execute registers at the next clock, so the two younger wrong-path instructions are dropped.

A small state machine records what was injected. RUN is the normal state. STALL follows a load-use hold, and SQUASH follows a branch flush. In STALL and SQUASH the execute stage holds a bubble, so that cycle's execute-stage inputs are ignored. Both states return to RUN after one cycle. The transitions are: RUN to SQUASH on a taken branch, RUN to STALL on a load-use hazard with no taken branch, RUN to RUN otherwise, and STALL to RUN and SQUASH to RUN always.

Top module: `hazard_fwd_unit`

## Requirements
- R1: While reset is applied, with all inputs zero, every control output is 0 and both selects are 00.
- R2: In RUN, if the execute/memory stage writes (write enable 1) a nonzero register equal to an operand's source, that operand's select is 10.
- R3: In RUN, if only the memory/write-back stage writes a nonzero register equal to an operand's source, the select is 01. With no match the select is 00, meaning the register file.
- R4: When both later stages match the same source, the execute/memory stage wins and the select is 10.
- R5: Register number 0 is never bypassed. A source of 0 always gives select 00.
- R6: A stage whose write enable is 0 is never a bypass source, even if its register number matches.
- R7: In RUN, a load in execute (memory-read 1, write enable 1, nonzero destination) whose destination equals either decode source raises pc_hold, ifid_hold and idex_bubble in that same cycle, with ifid_clear 0.
- R8: No stall occurs when the execute instruction is not a load, when its destination is 0, or when its destination matches neither decode source.
- R9: In RUN, a taken branch raises ifid_clear and idex_bubble with pc_hold and ifid_hold at 0. This takes precedence over a load-use hazard in the same cycle.
- R10: In the cycle right after a stall or a flush, every output is 0 and both selects are 00, whatever the execute-stage inputs are.
- R11: A stall lasts exactly one cycle. In the cycle after that, a fresh hazard is acted on again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs1 | input | 5 | First source register of the decode instruction |
| id_rs2 | input | 5 | Second source register of the decode instruction |
| ex_rs1 | input | 5 | First source register of the execute instruction |
| ex_rs2 | input | 5 | Second source register of the execute instruction |
| ex_rd | input | 5 | Destination of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_memrd | input | 1 | Execute instruction is a load |
| ex_br_taken | input | 1 | Branch in execute is taken |
| mem_rd | input | 5 | Destination held in execute/memory register |
| mem_wen | input | 1 | Write enable held in execute/memory register |
| wb_rd | input | 5 | Destination held in memory/write-back register |
| wb_wen | input | 1 | Write enable held in memory/write-back register |
| fwd_a | output | 2 | Bypass select, operand A (00 file, 01 write-back, 10 memory) |
| fwd_b | output | 2 | Bypass select, operand B (same encoding) |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| ifid_clear | output | 1 | Load a no-op into the fetch/decode register |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |

## Verification
A taken branch and a load-use hazard can arrive in the same cycle, and a bypass match can coincide with either of them. The bench provokes this with directed cycles that raise all three together. It also uses random stimulus drawn from a register range of only four values, so these collisions are frequent. Each cycle is judged against a bench model of the state machine: the flush must win, no hold may appear, and the following cycle must be fully quiet. A stall is then followed by another load-use hazard to show that the second one is honoured after exactly one quiet cycle.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } byp_sel_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'b00,
        ST_STALL  = 2'b01,
        ST_SQUASH = 2'b10
    } hz_state_e;
endpackage

// File: rtl/byp_select.sv
module byp_select #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic          ex_live,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    output logic [1:0]    sel
);
    import hzd_pkg::*;
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic src_valid, hit_mem, hit_wb;

    always_comb begin
        src_valid = ex_live && (src != ZERO_REG);
        hit_mem   = src_valid && mem_wen && (mem_rd == src);
        hit_wb    = src_valid && wb_wen  && (wb_rd  == src);
        if (hit_mem)     sel = SEL_MEM;
        else if (hit_wb) sel = SEL_WB;
        else             sel = SEL_RF;
    end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0][AW-1:0] id_src,
    input  logic [AW-1:0]           ex_rd,
    input  logic                    ex_wen,
    input  logic                    ex_memrd,
    output logic                    hazard
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic            is_load;
    logic [NSRC-1:0] hit;

    assign is_load = ex_memrd && ex_wen && (ex_rd != ZERO_REG);

    for (genvar g = 0; g < NSRC; g++) begin : g_cmp
        assign hit[g] = is_load && (id_src[g] == ex_rd);
    end

    assign hazard = |hit;
endmodule

// File: rtl/hazard_fsm.sv
module hazard_fsm (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                br_taken,
    input  logic                lu_hazard,
    output hzd_pkg::hz_state_e  state,
    output logic                ex_live,
    output logic                pc_hold,
    output logic                ifid_hold,
    output logic                ifid_clear,
    output logic                idex_bubble
);
    import hzd_pkg::*;

    hz_state_e next_state;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= next_state;
    end

    always_comb begin
        ex_live     = 1'b0;
        pc_hold     = 1'b0;
        ifid_hold   = 1'b0;
        ifid_clear  = 1'b0;
        idex_bubble = 1'b0;
        next_state  = ST_RUN;
        unique case (state)
            ST_RUN: begin
                ex_live = 1'b1;
                if (br_taken) begin
                    ifid_clear  = 1'b1;
                    idex_bubble = 1'b1;
                    next_state  = ST_SQUASH;
                end else if (lu_hazard) begin
                    pc_hold     = 1'b1;
                    ifid_hold   = 1'b1;
                    idex_bubble = 1'b1;
                    next_state  = ST_STALL;
                end
            end
            ST_STALL:  next_state = ST_RUN;
            ST_SQUASH: next_state = ST_RUN;
            default:   next_state = ST_RUN;
        endcase
    end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic [AW-1:0] ex_rs1,
    input  logic [AW-1:0] ex_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_memrd,
    input  logic          ex_br_taken,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          ifid_clear,
    output logic          idex_bubble
);
    import hzd_pkg::*;
    localparam int NSRC = 2;

    hz_state_e                state;
    logic                     ex_live;
    logic                     lu_hazard;
    logic [NSRC-1:0][AW-1:0]  ex_src;
    logic [NSRC-1:0][AW-1:0]  id_src;
    logic [NSRC-1:0][1:0]     sel;

    assign ex_src = {ex_rs2, ex_rs1};
    assign id_src = {id_rs2, id_rs1};

    for (genvar g = 0; g < NSRC; g++) begin : g_opnd
        byp_select #(.AW(AW)) u_sel (
            .src     (ex_src[g]),
            .ex_live (ex_live),
            .mem_rd  (mem_rd),
            .mem_wen (mem_wen),
            .wb_rd   (wb_rd),
            .wb_wen  (wb_wen),
            .sel     (sel[g])
        );
    end

    assign fwd_a = sel[0];
    assign fwd_b = sel[1];

    load_use_detect #(.AW(AW), .NSRC(NSRC)) u_lu (
        .id_src   (id_src),
        .ex_rd    (ex_rd),
        .ex_wen   (ex_wen),
        .ex_memrd (ex_memrd),
        .hazard   (lu_hazard)
    );

    hazard_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .br_taken    (ex_br_taken),
        .lu_hazard   (lu_hazard),
        .state       (state),
        .ex_live     (ex_live),
        .pc_hold     (pc_hold),
        .ifid_hold   (ifid_hold),
        .ifid_clear  (ifid_clear),
        .idex_bubble (idex_bubble)
    );
endmodule

// File: rtl/hazard_fwd_unit_chk.sv
module hazard_fwd_unit_chk #(
    parameter int AW = 5
) (
    input logic               clk,
    input logic               rst_n,
    input hzd_pkg::hz_state_e state,
    input logic [AW-1:0]      id_rs1,
    input logic [AW-1:0]      id_rs2,
    input logic [AW-1:0]      ex_rs1,
    input logic [AW-1:0]      ex_rd,
    input logic               ex_wen,
    input logic               ex_memrd,
    input logic               ex_br_taken,
    input logic [AW-1:0]      mem_rd,
    input logic               mem_wen,
    input logic [AW-1:0]      wb_rd,
    input logic               wb_wen,
    input logic [1:0]         fwd_a,
    input logic [1:0]         fwd_b,
    input logic               pc_hold,
    input logic               ifid_hold,
    input logic               ifid_clear,
    input logic               idex_bubble
);
    import hzd_pkg::*;

    p_mem_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && ex_rs1 != '0 && mem_wen && wb_wen &&
         mem_rd == ex_rs1 && wb_rd == ex_rs1) |-> fwd_a == 2'b10);

    p_no_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs1 == '0) |-> fwd_a == 2'b00);

    p_load_use_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !ex_br_taken && ex_memrd && ex_wen && ex_rd != '0 &&
         (ex_rd == id_rs1 || ex_rd == id_rs2))
        |-> (pc_hold && ifid_hold && idex_bubble && !ifid_clear));

    p_branch_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && ex_br_taken)
        |-> (ifid_clear && idex_bubble && !pc_hold && !ifid_hold));

    p_quiet_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_hold || ifid_clear)
        |=> (!pc_hold && !ifid_hold && !ifid_clear && !idex_bubble &&
             fwd_a == 2'b00 && fwd_b == 2'b00));
endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/hazard_fwd_unit_tb.sv
`timescale 1ns/1ps
module hazard_fwd_unit_tb;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
    logic [AW-1:0] mem_rd = '0, wb_rd = '0;
    logic          ex_wen = 1'b0, ex_memrd = 1'b0, ex_br_taken = 1'b0;
    logic          mem_wen = 1'b0, wb_wen = 1'b0;
    logic [1:0]    fwd_a, fwd_b;
    logic          pc_hold, ifid_hold, ifid_clear, idex_bubble;

    int n_chk = 0;
    int n_bad = 0;
    int mstate = 0;   // 0 run, 1 after stall, 2 after flush
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hazard_fwd_unit #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_memrd(ex_memrd), .ex_br_taken(ex_br_taken),
        .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
        .ifid_clear(ifid_clear), .idex_bubble(idex_bubble)
    );

    function automatic logic [1:0] exp_sel(logic [AW-1:0] s, bit live);
        if (!live || s == 0)              return 2'b00;
        if (mem_wen && mem_rd == s)       return 2'b10;
        if (wb_wen && wb_rd == s)         return 2'b01;
        return 2'b00;
    endfunction

    // {fwd_a, fwd_b, pc_hold, ifid_hold, ifid_clear, idex_bubble}
    function automatic logic [7:0] expect_vec(int st);
        bit live = (st == 0);
        bit lu   = ex_memrd && ex_wen && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
        logic [3:0] ctl = 4'b0000;
        if (live && ex_br_taken) ctl = 4'b0011;
        else if (live && lu)     ctl = 4'b1101;
        return {exp_sel(ex_rs1, live), exp_sel(ex_rs2, live), ctl};
    endfunction

    task automatic check_now(string tag);
        logic [7:0] got = {fwd_a, fwd_b, pc_hold, ifid_hold, ifid_clear, idex_bubble};
        logic [7:0] exp = expect_vec(mstate);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // drive at negedge, sample 1 ns later, then advance model state for the coming edge
    task automatic step(string tag);
        logic [7:0] e;
        #1;
        check_now(tag);
        e = expect_vec(mstate);
        if (e[1] && e[0])      mstate = 2;
        else if (e[3] && e[0]) mstate = 1;
        else                   mstate = 0;
        @(negedge clk);
    endtask

    task automatic clear_in();
        id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
        ex_wen = 0; ex_memrd = 0; ex_br_taken = 0;
        mem_rd = 0; mem_wen = 0; wb_rd = 0; wb_wen = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        #1; check_now("R1 reset idle");
        @(negedge clk);
        rst_n = 1'b1;
        mstate = 0;
        @(negedge clk);

        clear_in(); mem_rd = 3; mem_wen = 1; ex_rs1 = 3;            step("R2 exmem bypass");
        clear_in(); wb_rd = 4; wb_wen = 1; ex_rs2 = 4;              step("R3 memwb bypass");
        clear_in(); ex_rs1 = 7;                                     step("R3 no match file");
        clear_in(); mem_rd = 5; wb_rd = 5; mem_wen = 1; wb_wen = 1;
        ex_rs1 = 5; ex_rs2 = 5;                                     step("R4 priority");
        clear_in(); mem_wen = 1; wb_wen = 1;                        step("R5 reg zero");
        clear_in(); mem_rd = 9; wb_rd = 9; ex_rs1 = 9;              step("R6 wen low");
        clear_in(); ex_memrd = 1; ex_wen = 1; ex_rd = 6; id_rs2 = 6;
        mem_rd = 2; mem_wen = 1; ex_rs1 = 2;                        step("R7 load use");
        ex_br_taken = 1;                                            step("R10 quiet after stall");
        clear_in(); ex_memrd = 1; ex_wen = 1; ex_rd = 8; id_rs1 = 8; step("R11 second stall");
        clear_in();                                                 step("R10 idle after stall");
        clear_in(); ex_memrd = 1; ex_wen = 1; ex_rd = 8; id_rs1 = 1; id_rs2 = 2; step("R8 no match");
        clear_in(); ex_wen = 1; ex_rd = 8; id_rs1 = 8;              step("R8 not load");
        clear_in(); ex_memrd = 1; ex_wen = 1; ex_rd = 0; id_rs1 = 0; step("R8 dest zero");
        clear_in(); ex_br_taken = 1; ex_memrd = 1; ex_wen = 1; ex_rd = 3; id_rs1 = 3;
        mem_rd = 3; mem_wen = 1; ex_rs1 = 3;                        step("R9 branch beats stall");
        wb_rd = 3; wb_wen = 1;                                      step("R10 quiet after flush");
        clear_in();                                                 step("R9 back to run");

        for (int i = 0; i < 2000; i++) begin
            id_rs1 = AW'($urandom_range(0, 3)); id_rs2 = AW'($urandom_range(0, 3));
            ex_rs1 = AW'($urandom_range(0, 3)); ex_rs2 = AW'($urandom_range(0, 3));
            ex_rd  = AW'($urandom_range(0, 3));
            mem_rd = AW'($urandom_range(0, 3)); wb_rd = AW'($urandom_range(0, 3));
            ex_wen = 1'($urandom_range(0, 1)); ex_memrd = 1'($urandom_range(0, 1));
            mem_wen = 1'($urandom_range(0, 1)); wb_wen = 1'($urandom_range(0, 1));
            ex_br_taken = ($urandom_range(0, 7) == 0);
            step("random mix");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule